// File: doc/BRIEF.md
# Vectored Interrupt Controller with Combined-Vector Signalling

This block gathers level-sensitive interrupt requests from up to 32 peripheral sources and reduces them to one request line and one vector number for a CPU core. A software-writable enable register decides which sources may reach the core. Each set bit enables the matching source. A read-only view returns the requests that currently pass the enables. When exactly one enabled source is active, the core receives that source's own vector. When two or more are active together, the core receives one shared "multiple" vector. Software then reads the pending view and services every set bit in one pass.

A separate non-maskable input is edge-captured into a sticky flag. It ignores the enable register, takes precedence over every other source, and uses vector 0x00. The vector output is registered. Once a vector with a live request is loaded, it is frozen until the core pulses the acknowledge input. The controller then reloads from the state seen in that cycle. Acknowledging while the NMI vector is shown retires the NMI flag.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the enable register is all zeros, `irq_o` is low, `vec_o` is 0x00 and no vector is held.
- R2: A write with `sel_i`=0 loads the whole enable register from `wdata_i` at the clock edge. A read with `sel_i`=0 returns it. Clearing one bit by read-modify-write leaves every other bit unchanged, including bit 26, the timer source.
- R3: A read with `sel_i`=1 returns the bitwise AND of `req_i` and the enable register, with no latching. A write with `sel_i`=1 leaves the enable register unchanged. A disabled source never reaches `irq_o` or `vec_o`.
- R4: `irq_o` is high in exactly the cycles where the pending view is nonzero or the NMI flag is set.
- R5: When exactly one enabled source n is active and no vector is held, the next edge loads `vec_o` = 0x31 + n.
- R6: When two or more enabled sources are active and no vector is held, the next edge loads `vec_o` = 0x30.
- R7: A rising edge on `nmi_i` sets a sticky flag at the next clock edge, regardless of the enable register. While the flag is set, the next vector load selects 0x00 ahead of any other source.
- R8: Asserting `ack_i` while a held 0x00 vector is shown clears the NMI flag at that edge, unless a new NMI edge arrives in the same cycle.
- R9: A vector loaded while any request or the NMI flag was present is held unchanged until the first cycle with `ack_i` high. At that edge `vec_o` reloads from the current state, or drops to 0x00 with no hold when nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| sel_i | input | 1 | Register select: 0 enable register, 1 pending view |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for the selected register |
| req_i | input | 32 | Level-sensitive source requests, bit n is source n |
| nmi_i | input | 1 | Non-maskable interrupt, captured on its rising edge |
| ack_i | input | 1 | Core acknowledge of the presented vector |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | 8 | Registered vector number |

## Verification
The assertions assume that `ack_i` stays low while no vector is held. They also assume that `req_i`, `nmi_i` and the register port change only away from the rising clock edge. The stimulus drives every input one nanosecond after the edge. It raises `ack_i` only for single cycles that follow a loaded vector. A cycle-level behavioural model of the enable register, the NMI flag and the vector hold tracks the block on every clock. Directed sequences cover single sources, multiple sources, hold-versus-reload and the NMI retire path.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int VEC_W = 8;
  typedef logic [VEC_W-1:0] vec_t;

  localparam vec_t NMI_VEC   = 8'h00;
  localparam vec_t MULTI_VEC = 8'h30;
  localparam vec_t FIRST_VEC = 8'h31;

  typedef enum logic {
    SEL_ENABLE  = 1'b0,
    SEL_PENDING = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
  import irq_vec_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic               sel_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic [NUM_SRC-1:0] req_i,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] rdata_o
);
  logic [NUM_SRC-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   en_q <= '0;
    else if (we_i && reg_sel_e'(sel_i) == SEL_ENABLE) en_q <= wdata_i;
  end

  // level-sensitive: nothing latched here
  assign pend_o  = req_i & en_q;
  assign en_o    = en_q;
  assign rdata_o = (reg_sel_e'(sel_i) == SEL_PENDING) ? pend_o : en_q;
endmodule

// File: rtl/irq_nmi_capture.sv
module irq_nmi_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_i,
  input  logic clr_i,
  output logic flag_o
);
  logic nmi_d_q, flag_q, rise;

  assign rise = nmi_i & ~nmi_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_d_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      nmi_d_q <= nmi_i;
      flag_q  <= rise | (flag_q & ~clr_i);
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_vec_encode.sv
module irq_vec_encode #(
  parameter int NUM_SRC = 32,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] pend_i,
  output logic               any_o,
  output logic               multi_o,
  output logic [IDX_W-1:0]   idx_o
);
  assign any_o   = |pend_i;
  // clearing the lowest set bit leaves something iff two or more are set
  assign multi_o = |(pend_i & (pend_i - NUM_SRC'(1)));

  always_comb begin
    idx_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic               sel_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] rdata_o,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               nmi_i,
  input  logic               ack_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_o
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] en_q, pend;
  logic               nmi_flag, nmi_clr, nmi_live;
  logic               any, multi;
  logic [IDX_W-1:0]   idx;
  vec_t               vec_q, vec_d;
  logic               hold_q, hold_d, load;

  irq_enable_reg #(.NUM_SRC(NUM_SRC)) u_en (
    .clk_i, .rst_ni, .we_i, .sel_i, .wdata_i, .req_i,
    .en_o(en_q), .pend_o(pend), .rdata_o
  );

  irq_nmi_capture u_nmi (
    .clk_i, .rst_ni, .nmi_i, .clr_i(nmi_clr), .flag_o(nmi_flag)
  );

  irq_vec_encode #(.NUM_SRC(NUM_SRC)) u_enc (
    .pend_i(pend), .any_o(any), .multi_o(multi), .idx_o(idx)
  );

  assign nmi_clr  = ack_i & hold_q & (vec_q == NMI_VEC);
  assign nmi_live = nmi_flag & ~nmi_clr;
  assign load     = ~hold_q | ack_i;

  always_comb begin
    hold_d = nmi_live | any;
    if (nmi_live)   vec_d = NMI_VEC;
    else if (multi) vec_d = MULTI_VEC;
    else if (any)   vec_d = FIRST_VEC + vec_t'(idx);
    else            vec_d = NMI_VEC;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q  <= NMI_VEC;
      hold_q <= 1'b0;
    end else if (load) begin
      vec_q  <= vec_d;
      hold_q <= hold_d;
    end
  end

  assign irq_o = any | nmi_flag;
  assign vec_o = vec_q;
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk
  import irq_vec_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               we_i,
  input logic               sel_i,
  input logic [NUM_SRC-1:0] wdata_i,
  input logic [NUM_SRC-1:0] req_i,
  input logic               nmi_i,
  input logic               ack_i,
  input logic               irq_o,
  input logic [VEC_W-1:0]   vec_o,
  input logic [NUM_SRC-1:0] en_q,
  input logic               nmi_flag,
  input logic               hold_q
);
  // R2
  en_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !sel_i) |=> en_q == $past(wdata_i));

  // R3
  pend_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i) |=> $stable(en_q));

  // R6
  multi_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_q && !nmi_flag && $countones(req_i & en_q) >= 2) |=> vec_o == MULTI_VEC);

  // R7
  nmi_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_i && !nmi_flag) |=> irq_o);

  // R8
  nmi_retire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && hold_q && vec_o == NMI_VEC && !nmi_i) |=> !nmi_flag);

  // R9
  vec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && !ack_i) |=> $stable(vec_o));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i, .rst_ni, .we_i, .sel_i, .wdata_i, .req_i, .nmi_i, .ack_i,
  .irq_o, .vec_o, .en_q, .nmi_flag, .hold_q
);

// File: tb/irq_vec_ctrl_test.sv
module irq_vec_ctrl_test;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        we = 1'b0, sel = 1'b0, nmi = 1'b0, ack = 1'b0;
  logic [31:0] wdata = '0, req = '0, rdata;
  logic        irq;
  logic [7:0]  vec;
  int          n_chk = 0, n_fail = 0, cyc = 0;
  bit          done = 1'b0;

  // behavioural model state
  logic [31:0] m_en;
  logic [7:0]  m_vec;
  bit          m_hold, m_nmi, m_nmi_prev;

  always #2 clk = ~clk;

  irq_vec_ctrl uut (
    .clk_i(clk), .rst_ni, .we_i(we), .sel_i(sel), .wdata_i(wdata),
    .rdata_o(rdata), .req_i(req), .nmi_i(nmi), .ack_i(ack),
    .irq_o(irq), .vec_o(vec)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_en = '0; m_vec = '0; m_hold = 0; m_nmi = 0; m_nmi_prev = 0;
    end else begin
      bit clr, live;
      int cnt, low;
      logic [31:0] p;
      clr  = m_hold && ack && m_vec == 8'h00;
      live = m_nmi && !clr;
      p    = req & m_en;
      cnt  = 0; low = 0;
      for (int i = 31; i >= 0; i--) if (p[i]) begin cnt++; low = i; end
      if (!m_hold || ack) begin
        m_hold = live || cnt > 0;
        if (live)         m_vec = 8'h00;
        else if (cnt > 1) m_vec = 8'h30;
        else if (cnt == 1) m_vec = 8'(8'h31 + low);
        else              m_vec = 8'h00;
      end
      m_nmi      = (nmi && !m_nmi_prev) || live;
      m_nmi_prev = nmi;
      if (we && !sel) m_en = wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      check(sel ? "R3" : "R2", rdata, sel ? (req & m_en) : m_en);
      check("R4", {31'b0, irq}, {31'b0, (|(req & m_en)) | m_nmi});
      check(m_hold ? "R9" : "R5", {24'b0, vec}, {24'b0, m_vec});
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(bit s, logic [31:0] d);
    we = 1; sel = s; wdata = d; tick(); we = 0; sel = 0;
  endtask

  task automatic do_ack();
    ack = 1; tick(); ack = 0;
  endtask

  initial begin
    #1; tick(); tick();
    rst_ni = 1'b1; #1;
    // R1 reset state
    check("R1", {31'b0, irq}, 32'h0);
    check("R1", {24'b0, vec}, 32'h0);
    check("R1", rdata, 32'h0);

    // R5 single source 0
    wr(0, 32'h1); req = 32'h1; tick();
    check("R5", {24'b0, vec}, 32'h31);
    check("R4", {31'b0, irq}, 32'h1);
    req = 0; do_ack();
    check("R9", {24'b0, vec}, 32'h0);

    // R6 two sources together, R3 pending view
    wr(0, 32'hFFFF_FFFF); req = 32'h0401_0000; tick();
    check("R6", {24'b0, vec}, 32'h30);
    sel = 1; #1; check("R3", rdata, 32'h0401_0000); sel = 0;
    req = 0; do_ack();

    // R9 hold until acknowledge, then reload
    req = 32'h8; tick();
    check("R5", {24'b0, vec}, 32'h34);
    req = 32'h20; tick(); tick();
    check("R9", {24'b0, vec}, 32'h34);
    do_ack();
    check("R9", {24'b0, vec}, 32'h36);
    req = 0; do_ack();

    // R3 disabled source ignored, write to pending view ignored
    wr(0, ~32'h80); req = 32'h80; tick();
    check("R3", {31'b0, irq}, 32'h0);
    check("R3", {24'b0, vec}, 32'h0);
    wr(1, 32'h0); #1;
    check("R3", rdata, ~32'h80);
    req = 0;

    // R2 read-modify-write keeps timer bit 26
    wr(0, 32'h0400_00FF);
    wr(0, rdata & ~32'h1); #1;
    check("R2", rdata, 32'h0400_00FE);
    req = 32'h0400_0000; tick();
    check("R5", {24'b0, vec}, 32'h4B);
    req = 0; do_ack();

    // R7 NMI ignores enables and wins; R8 retire on acknowledge
    wr(0, 32'h0);
    nmi = 1; tick(); nmi = 0;
    check("R7", {31'b0, irq}, 32'h1);
    tick();
    check("R7", {24'b0, vec}, 32'h0);
    check("R7", {31'b0, irq}, 32'h1);
    do_ack();
    check("R8", {31'b0, irq}, 32'h0);

    // R7 priority over enabled sources
    wr(0, 32'h3); req = 32'h3; nmi = 1; tick(); nmi = 0;
    check("R6", {24'b0, vec}, 32'h30);
    do_ack();
    check("R7", {24'b0, vec}, 32'h0);
    req = 0; do_ack();
    check("R8", {31'b0, irq}, 32'h0);
    tick(); tick();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule